// File: doc/BRIEF.md
# Host FIFO Controller with Status Interrupts

This block sits between a byte-wide host register port and a serial data engine. It holds one FIFO for each direction. The host writes bytes for the engine to send and reads bytes the engine has received. The engine pulls transmit bytes and delivers receive bytes through valid/ready handshakes. The host port is a small register file. A data register is written to push into the transmit FIFO and read to pop the receive FIFO. The other registers are status, interrupt pending, interrupt mask and control.

Four level flags describe the FIFOs: transmit not-full, receive not-empty, transmit half-full and receive half-full. Every rising or falling edge of a flag latches a pending bit for that source. The interrupt output is raised while any pending bit is also enabled in the mask. The control register selects between a 128-byte and a 16-byte FIFO depth, and a change of depth empties both FIFOs. It also sets a DMA mode, which turns two general status outputs into a transmit request and a receive request, so that a DMA engine can service the FIFOs without polling.

Top module: `host_fifo_ctrl`

## Requirements
- R1: Bytes written to address 0 leave on eng_tx_data_o in write order. eng_tx_valid_o is high whenever the transmit FIFO holds a byte, and a byte is removed on each cycle in which eng_tx_valid_o and eng_tx_ready_i are both high.
- R2: eng_rx_ready_o is high while the receive FIFO is below its depth. A byte is stored on each cycle in which eng_rx_valid_i and eng_rx_ready_o are both high. A read of address 0 returns the oldest stored byte on host_rdata_o in the same cycle and removes it.
- R3: Control register (address 4): bit 0 selects the deep mode (128 bytes), which is set after reset. When bit 0 is clear the depth is 16 bytes. Bit 1 enables DMA mode. A read returns these two bits.
- R4: Status register (address 1) bits: 0 transmit not-full, 1 receive not-empty, 2 transmit half-full, 3 receive half-full, 4 transmit overrun, 5 receive underrun, 6 transmit empty, 7 receive full.
- R5: Each half-full flag is high while its FIFO holds 8 or more bytes.
- R6: A data write to a full transmit FIFO is discarded and sets status bit 4. The bit stays set until the host writes a one to status bit 4.
- R7: A data read from an empty receive FIFO returns zero and sets status bit 5. The bit stays set until the host writes a one to status bit 5.
- R8: Any change of flag k (status bit k, k = 0 to 3) sets pending bit k at address 2 one cycle after the change. A set pending bit stays set until the host writes a one to it. If a new change and a clear arrive in the same cycle, the change wins.
- R9: irq_o is high exactly while some pending bit has its mask bit (address 3, bits 3:0) set.
- R10: When DMA mode is on, sig_a_o is high while the transmit FIFO is empty and sig_b_o is high while the receive FIFO holds at least one byte. When DMA mode is off, they copy aux_a_i and aux_b_i.
- R11: A control write that changes bit 0 empties both FIFOs at that clock edge. Engine traffic in the same cycle is lost.
- R12: After reset both FIFOs are empty, status reads 0x41, control reads 0x01, and pending, mask, overrun and underrun are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_addr_i | input | 3 | Register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid in the cycle of host_rd_i |
| eng_tx_valid_o | output | 1 | Transmit byte available to the engine |
| eng_tx_data_o | output | 8 | Oldest transmit byte |
| eng_tx_ready_i | input | 1 | Engine takes the transmit byte |
| eng_rx_valid_i | input | 1 | Engine offers a receive byte |
| eng_rx_data_i | input | 8 | Receive byte |
| eng_rx_ready_o | output | 1 | Receive FIFO can accept a byte |
| aux_a_i | input | 1 | Status level shown on sig_a_o outside DMA mode |
| aux_b_i | input | 1 | Status level shown on sig_b_o outside DMA mode |
| sig_a_o | output | 1 | aux_a_i, or the transmit request in DMA mode |
| sig_b_o | output | 1 | aux_b_i, or the receive request in DMA mode |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench fills the transmit FIFO exactly to each depth and then writes one more byte. A design whose full test is off by one would either lose a byte that belongs in the FIFO or keep the extra byte, and the reference queue would see a wrong byte order or a missing overrun. Reads from an empty receive FIFO must return zero and set the underrun bit. The bench changes the depth while both FIFOs hold data to catch a flush that is missed or that leaves stale pointers; either fault would release stale bytes to the engine. Random traffic puts interrupt-clear writes in the same cycle as flag edges, pushes and pops in the same cycle, and mask changes. A design that lets a clear win over a new edge would drop an interrupt, and one that detects only rising edges would miss a FIFO draining below half full.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned N_FLAGS = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 3'd0,
    REG_STAT = 3'd1,
    REG_PEND = 3'd2,
    REG_MASK = 3'd3,
    REG_CTRL = 3'd4
  } reg_addr_e;

  // flag vector order, shared by status, pending and mask
  localparam int unsigned FL_TX_NF = 0;
  localparam int unsigned FL_RX_NE = 1;
  localparam int unsigned FL_TX_HF = 2;
  localparam int unsigned FL_RX_HF = 3;

  localparam int unsigned ST_OVR = 4;
  localparam int unsigned ST_UNR = 5;
endpackage

// File: rtl/hf_byte_fifo.sv
module hf_byte_fifo #(
  parameter int unsigned W       = 8,
  parameter int unsigned DEEP    = 128,
  parameter int unsigned SHALLOW = 16,
  parameter int unsigned HALF    = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         deep_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 data_o,
  output logic [$clog2(DEEP+1)-1:0]    count_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic                         half_o
);
  localparam int unsigned PW = $clog2(DEEP);
  localparam int unsigned CW = $clog2(DEEP+1);

  logic [W-1:0]  mem_q [DEEP];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, limit;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEEP-1)) ? '0 : p + PW'(1);
  endfunction

  assign limit   = deep_i ? CW'(DEEP) : CW'(SHALLOW);
  assign full_o  = (cnt_q >= limit);
  assign empty_o = (cnt_q == '0);
  assign half_o  = (cnt_q >= CW'(HALF));
  assign count_o = cnt_q;
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/hf_flag_irq.sv
module hf_flag_irq #(
  parameter int unsigned N         = 4,
  parameter logic [N-1:0] RST_FLAGS = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] prev_q, pend_q;

  for (genvar k = 0; k < N; k++) begin : g_src
    // a new edge wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[k] <= RST_FLAGS[k];
        pend_q[k] <= 1'b0;
      end else begin
        prev_q[k] <= flags_i[k];
        pend_q[k] <= (pend_q[k] && !clr_i[k]) || (flags_i[k] ^ prev_q[k]);
      end
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & mask_i);
endmodule

// File: rtl/hf_host_regs.sv
module hf_host_regs
  import hfifo_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  tx_full_i,
  input  logic                  tx_empty_i,
  input  logic                  rx_full_i,
  input  logic                  rx_empty_i,
  input  logic [DATA_W-1:0]     rx_data_i,
  input  logic [N_FLAGS-1:0]    flags_i,
  input  logic [N_FLAGS-1:0]    pend_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  tx_push_o,
  output logic                  rx_pop_o,
  output logic [N_FLAGS-1:0]    pend_clr_o,
  output logic [N_FLAGS-1:0]    mask_o,
  output logic                  deep_o,
  output logic                  dma_o,
  output logic                  flush_o
);
  logic                 deep_q, dma_q, ovr_q, unr_q;
  logic [N_FLAGS-1:0]   mask_q;
  logic                 wr_data, wr_stat, wr_pend, wr_mask, wr_ctrl, rd_data;
  logic                 ovr_set, unr_set;
  logic [DATA_W-1:0]    rd_mux;

  assign wr_data = wr_i && (addr_i == REG_DATA);
  assign wr_stat = wr_i && (addr_i == REG_STAT);
  assign wr_pend = wr_i && (addr_i == REG_PEND);
  assign wr_mask = wr_i && (addr_i == REG_MASK);
  assign wr_ctrl = wr_i && (addr_i == REG_CTRL);
  assign rd_data = rd_i && (addr_i == REG_DATA);

  assign tx_push_o  = wr_data;
  assign rx_pop_o   = rd_data;
  assign pend_clr_o = wr_pend ? wdata_i[N_FLAGS-1:0] : '0;
  assign flush_o    = wr_ctrl && (wdata_i[0] != deep_q);
  assign ovr_set    = wr_data && tx_full_i;
  assign unr_set    = rd_data && rx_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deep_q <= 1'b1;
      dma_q  <= 1'b0;
      mask_q <= '0;
      ovr_q  <= 1'b0;
      unr_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        deep_q <= wdata_i[0];
        dma_q  <= wdata_i[1];
      end
      if (wr_mask) mask_q <= wdata_i[N_FLAGS-1:0];
      ovr_q <= (ovr_q && !(wr_stat && wdata_i[ST_OVR])) || ovr_set;
      unr_q <= (unr_q && !(wr_stat && wdata_i[ST_UNR])) || unr_set;
    end
  end

  always_comb begin
    case (addr_i)
      REG_DATA: rd_mux = rx_empty_i ? '0 : rx_data_i;
      REG_STAT: rd_mux = {rx_full_i, tx_empty_i, unr_q, ovr_q, flags_i};
      REG_PEND: rd_mux = {{(DATA_W-N_FLAGS){1'b0}}, pend_i};
      REG_MASK: rd_mux = {{(DATA_W-N_FLAGS){1'b0}}, mask_q};
      REG_CTRL: rd_mux = {{(DATA_W-2){1'b0}}, dma_q, deep_q};
      default:  rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_i ? rd_mux : '0;
  assign mask_o  = mask_q;
  assign deep_o  = deep_q;
  assign dma_o   = dma_q;
endmodule

// File: rtl/host_fifo_ctrl.sv
module host_fifo_ctrl
  import hfifo_pkg::*;
#(
  parameter int unsigned DEEP_DEPTH    = 128,
  parameter int unsigned SHALLOW_DEPTH = 16,
  parameter int unsigned HALF_LEVEL    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [2:0]        host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic              eng_tx_valid_o,
  output logic [7:0]        eng_tx_data_o,
  input  logic              eng_tx_ready_i,
  input  logic              eng_rx_valid_i,
  input  logic [7:0]        eng_rx_data_i,
  output logic              eng_rx_ready_o,
  input  logic              aux_a_i,
  input  logic              aux_b_i,
  output logic              sig_a_o,
  output logic              sig_b_o,
  output logic              irq_o
);
  localparam int unsigned CW = $clog2(DEEP_DEPTH+1);
  localparam logic [N_FLAGS-1:0] FLAGS_AT_RESET = N_FLAGS'(1) << FL_TX_NF;

  logic [CW-1:0]       tx_count, rx_count;
  logic                tx_full, tx_empty, tx_half;
  logic                rx_full, rx_empty, rx_half;
  logic [DATA_W-1:0]   rx_head;
  logic                tx_push, rx_pop, flush, deep, dma;
  logic [N_FLAGS-1:0]  flags, pend, pend_clr, mask;

  hf_byte_fifo #(.W(DATA_W), .DEEP(DEEP_DEPTH), .SHALLOW(SHALLOW_DEPTH), .HALF(HALF_LEVEL)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .deep_i(deep),
    .push_i(tx_push), .data_i(host_wdata_i), .pop_i(eng_tx_ready_i),
    .data_o(eng_tx_data_o), .count_o(tx_count),
    .full_o(tx_full), .empty_o(tx_empty), .half_o(tx_half)
  );

  hf_byte_fifo #(.W(DATA_W), .DEEP(DEEP_DEPTH), .SHALLOW(SHALLOW_DEPTH), .HALF(HALF_LEVEL)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .deep_i(deep),
    .push_i(eng_rx_valid_i), .data_i(eng_rx_data_i), .pop_i(rx_pop),
    .data_o(rx_head), .count_o(rx_count),
    .full_o(rx_full), .empty_o(rx_empty), .half_o(rx_half)
  );

  always_comb begin
    flags           = '0;
    flags[FL_TX_NF] = !tx_full;
    flags[FL_RX_NE] = !rx_empty;
    flags[FL_TX_HF] = tx_half;
    flags[FL_RX_HF] = rx_half;
  end

  hf_host_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(host_wr_i), .rd_i(host_rd_i), .addr_i(host_addr_i), .wdata_i(host_wdata_i),
    .tx_full_i(tx_full), .tx_empty_i(tx_empty), .rx_full_i(rx_full), .rx_empty_i(rx_empty),
    .rx_data_i(rx_head), .flags_i(flags), .pend_i(pend),
    .rdata_o(host_rdata_o), .tx_push_o(tx_push), .rx_pop_o(rx_pop),
    .pend_clr_o(pend_clr), .mask_o(mask), .deep_o(deep), .dma_o(dma), .flush_o(flush)
  );

  hf_flag_irq #(.N(N_FLAGS), .RST_FLAGS(FLAGS_AT_RESET)) u_irq (
    .clk_i, .rst_ni, .flags_i(flags), .clr_i(pend_clr), .mask_i(mask),
    .pend_o(pend), .irq_o(irq_o)
  );

  assign eng_tx_valid_o = !tx_empty;
  assign eng_rx_ready_o = !rx_full;
  assign sig_a_o        = dma ? tx_empty  : aux_a_i;
  assign sig_b_o        = dma ? !rx_empty : aux_b_i;
endmodule

// File: rtl/hf_fifo_checker.sv
module hf_fifo_checker #(
  parameter int unsigned DEEP    = 128,
  parameter int unsigned SHALLOW = 16,
  parameter int unsigned CW      = $clog2(DEEP+1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_wr_i,
  input logic [2:0]    host_addr_i,
  input logic [7:0]    host_wdata_i,
  input logic          eng_tx_valid_o,
  input logic          eng_tx_ready_i,
  input logic          eng_rx_ready_o,
  input logic          sig_a_o,
  input logic [CW-1:0] tx_cnt_i,
  input logic [CW-1:0] rx_cnt_i,
  input logic          deep_i,
  input logic          dma_i,
  input logic          ovr_i,
  input logic [3:0]    pend_i
);
  logic [CW-1:0] lim;
  logic [3:0]    clr;
  logic          depth_chg, data_wr;

  assign lim       = deep_i ? CW'(DEEP) : CW'(SHALLOW);
  assign clr       = (host_wr_i && host_addr_i == 3'd2) ? host_wdata_i[3:0] : 4'd0;
  assign depth_chg = host_wr_i && host_addr_i == 3'd4 && (host_wdata_i[0] != deep_i);
  assign data_wr   = host_wr_i && host_addr_i == 3'd0;

  a_r3_tx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_i <= lim);

  a_r2_no_ready_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt_i >= lim) |-> !eng_rx_ready_o);

  a_r1_pop_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_tx_valid_o && eng_tx_ready_i && !data_wr && !depth_chg)
      |=> (tx_cnt_i == $past(tx_cnt_i) - CW'(1)));

  a_r6_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !(host_wr_i && host_addr_i == 3'd1 && host_wdata_i[4])) |=> ovr_i);

  a_r8_pending_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_i & ~clr) & ~pend_i) == 4'd0));

  a_r11_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_chg |=> (tx_cnt_i == '0 && rx_cnt_i == '0));

  a_r10_tx_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_i && tx_cnt_i == '0) |-> sig_a_o);
endmodule

bind host_fifo_ctrl hf_fifo_checker #(.DEEP(DEEP_DEPTH), .SHALLOW(SHALLOW_DEPTH)) u_checker (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .host_wr_i(host_wr_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
  .eng_tx_valid_o(eng_tx_valid_o), .eng_tx_ready_i(eng_tx_ready_i),
  .eng_rx_ready_o(eng_rx_ready_o), .sig_a_o(sig_a_o),
  .tx_cnt_i(tx_count), .rx_cnt_i(rx_count),
  .deep_i(deep), .dma_i(dma), .ovr_i(u_regs.ovr_q), .pend_i(pend)
);

// File: tb/host_fifo_ctrl_bench.sv
module host_fifo_ctrl_bench;
  localparam int DEEP = 128;
  localparam int SHAL = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hwr = 1'b0, hrd = 1'b0;
  logic [2:0] ha = '0;
  logic [7:0] hwd = '0;
  logic [7:0] hrdata;
  logic       txv, rxr, sa, sb, irq;
  logic [7:0] txd;
  logic       txr = 1'b0, rxv = 1'b0, aa = 1'b0, ab = 1'b0;
  logic [7:0] rxd = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  host_fifo_ctrl u_host_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(hwr), .host_rd_i(hrd), .host_addr_i(ha), .host_wdata_i(hwd), .host_rdata_o(hrdata),
    .eng_tx_valid_o(txv), .eng_tx_data_o(txd), .eng_tx_ready_i(txr),
    .eng_rx_valid_i(rxv), .eng_rx_data_i(rxd), .eng_rx_ready_o(rxr),
    .aux_a_i(aa), .aux_b_i(ab), .sig_a_o(sa), .sig_b_o(sb), .irq_o(irq)
  );

  // reference model state
  logic [7:0] tq[$];
  logic [7:0] rq[$];
  bit         m_deep, m_dma, m_ovr, m_unr;
  logic [3:0] m_mask, m_pend, m_prev;

  function automatic int lim();
    return m_deep ? DEEP : SHAL;
  endfunction

  function automatic logic [3:0] cur_flags();
    return {rq.size() >= 8, tq.size() >= 8, rq.size() > 0, tq.size() < lim()};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      tq.delete(); rq.delete();
      m_deep = 1'b1; m_dma = 1'b0; m_ovr = 1'b0; m_unr = 1'b0;
      m_mask = '0; m_pend = '0; m_prev = 4'b0001;
    end else begin
      logic [3:0] cf, clr;
      bit tx_pop, tx_push, tx_full, rx_push, rx_pop, flush;
      cf      = cur_flags();
      clr     = (hwr && ha == 3'd2) ? hwd[3:0] : 4'd0;
      m_pend  = (m_pend & ~clr) | (cf ^ m_prev);
      m_prev  = cf;
      tx_pop  = txr && tq.size() > 0;
      tx_push = hwr && ha == 3'd0;
      tx_full = tq.size() >= lim();
      rx_push = rxv && rq.size() < lim();
      rx_pop  = hrd && ha == 3'd0 && rq.size() > 0;
      flush   = hwr && ha == 3'd4 && (hwd[0] != m_deep);
      if (hwr && ha == 3'd1) begin
        if (hwd[4]) m_ovr = 1'b0;
        if (hwd[5]) m_unr = 1'b0;
      end
      if (tx_push && tx_full) m_ovr = 1'b1;
      if (hrd && ha == 3'd0 && rq.size() == 0) m_unr = 1'b1;
      if (flush) begin
        tq.delete(); rq.delete();
      end else begin
        if (tx_pop) void'(tq.pop_front());
        if (tx_push && !tx_full) tq.push_back(hwd);
        if (rx_pop) void'(rq.pop_front());
        if (rx_push) rq.push_back(rxd);
      end
      if (hwr && ha == 3'd3) m_mask = hwd[3:0];
      if (hwr && ha == 3'd4) begin
        m_deep = hwd[0];
        m_dma  = hwd[1];
      end
    end
  end

  // per-cycle comparison, mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] er;
      logic [3:0] cf;
      cf = cur_flags();
      chk(txv == (tq.size() > 0), "R1 tx_valid", txv, tq.size() > 0);
      if (tq.size() > 0) chk(txd == tq[0], "R1 tx_data", txd, tq[0]);
      chk(rxr == (rq.size() < lim()), "R2 rx_ready", rxr, rq.size() < lim());
      chk(irq == |(m_pend & m_mask), "R9 irq", irq, |(m_pend & m_mask));
      chk(sa == (m_dma ? tq.size() == 0 : aa), "R10 sig_a", sa, m_dma ? tq.size() == 0 : aa);
      chk(sb == (m_dma ? rq.size() > 0 : ab), "R10 sig_b", sb, m_dma ? rq.size() > 0 : ab);
      if (hrd) begin
        case (ha)
          3'd0: er = (rq.size() > 0) ? rq[0] : 8'h00;
          3'd1: er = {rq.size() >= lim(), tq.size() == 0, m_unr, m_ovr, cf};
          3'd2: er = {4'h0, m_pend};
          3'd3: er = {4'h0, m_mask};
          3'd4: er = {6'h0, m_dma, m_deep};
          default: er = 8'h00;
        endcase
        chk(hrdata == er, "R4 R8 R3 register read", hrdata, er);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    hwr = 1'b1; ha = a; hwd = d;
    step();
    hwr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, input logic [7:0] exp, input string tag);
    hrd = 1'b1; ha = a;
    @(negedge clk);
    chk(hrdata == exp, tag, hrdata, exp);
    step();
    hrd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    step();
    // R12 reset state
    @(negedge clk);
    chk(txv == 1'b0 && rxr == 1'b1 && irq == 1'b0, "R12 reset outputs", {txv, rxr, irq}, 3'b010);
    step();
    hread(3'd1, 8'h41, "R12 reset status");
    hread(3'd4, 8'h01, "R12 reset control");
    hread(3'd2, 8'h00, "R12 reset pending");

    // R5 / R8 / R9: half-full edge on transmit
    hwrite(3'd3, 8'h0F);
    for (int i = 0; i < 9; i++) hwrite(3'd0, 8'(8'h30 + i));
    idle(2);
    hread(3'd1, 8'h05, "R5 tx half-full");
    hread(3'd2, 8'h04, "R8 pending on tx half rise");
    @(negedge clk); chk(irq == 1'b1, "R9 irq raised", irq, 1);
    step();
    hwrite(3'd2, 8'h04);
    @(negedge clk); chk(irq == 1'b0, "R8 pending cleared", irq, 0);
    step();
    // R1 drain with stalls
    for (int i = 0; i < 14; i++) begin txr = i[0]; step(); end
    txr = 1'b1; idle(6); txr = 1'b0;
    idle(2);
    hread(3'd1, 8'h41, "R1 tx drained");
    hread(3'd2, 8'h04, "R8 pending on tx half fall");
    hwrite(3'd2, 8'h0F);

    // R2 / R7: receive path and underrun
    for (int i = 0; i < 3; i++) begin rxv = 1'b1; rxd = 8'(8'hA0 + i); step(); end
    rxv = 1'b0;
    hread(3'd0, 8'hA0, "R2 rx byte 0");
    hread(3'd0, 8'hA1, "R2 rx byte 1");
    hread(3'd0, 8'hA2, "R2 rx byte 2");
    hread(3'd0, 8'h00, "R7 empty read returns zero");
    hread(3'd1, 8'h61, "R7 underrun set");
    hwrite(3'd1, 8'h20);
    hread(3'd1, 8'h41, "R7 underrun cleared");

    // R6: overrun at deep depth
    for (int i = 0; i < DEEP; i++) hwrite(3'd0, 8'(i));
    hwrite(3'd0, 8'hEE);
    hread(3'd1, 8'h14, "R6 overrun at 128");
    txr = 1'b1; idle(DEEP + 2); txr = 1'b0;
    hread(3'd1, 8'h51, "R6 overrun sticky after drain");
    hwrite(3'd1, 8'h10);
    hread(3'd1, 8'h41, "R6 overrun cleared");

    // R11 / R3: depth change flushes, shallow limits
    for (int i = 0; i < 3; i++) begin hwrite(3'd0, 8'(8'h50 + i)); end
    for (int i = 0; i < 3; i++) begin rxv = 1'b1; rxd = 8'(8'h60 + i); step(); end
    rxv = 1'b0;
    hwrite(3'd4, 8'h00);
    hread(3'd1, 8'h41, "R11 flush on depth change");
    hread(3'd4, 8'h00, "R3 control shallow");
    for (int i = 0; i < SHAL + 1; i++) hwrite(3'd0, 8'(8'hC0 + i));
    for (int i = 0; i < SHAL + 2; i++) begin rxv = 1'b1; rxd = 8'(8'hD0 + i); step(); end
    rxv = 1'b0;
    @(negedge clk); chk(rxr == 1'b0, "R3 rx full at 16", rxr, 0);
    step();
    hread(3'd1, 8'h9E, "R3 shallow full status");
    hwrite(3'd1, 8'h10);

    // R10: pin reassignment
    aa = 1'b1; ab = 1'b0; step();
    @(negedge clk); chk(sa == 1'b1 && sb == 1'b0, "R10 pass-through", {sa, sb}, 2'b10);
    step();
    hwrite(3'd4, 8'h02);
    @(negedge clk); chk(sa == 1'b0 && sb == 1'b1, "R10 dma requests", {sa, sb}, 2'b01);
    step();
    txr = 1'b1; idle(SHAL + 1); txr = 1'b0;
    @(negedge clk); chk(sa == 1'b1, "R10 tx request when empty", sa, 1);
    step();
    hwrite(3'd4, 8'h03);
    @(negedge clk); chk(sb == 1'b0, "R11 rx flushed back to deep", sb, 0);
    step();

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r   = int'($urandom_range(0, 99));
      txr = ($urandom_range(0, 3) != 0);
      rxv = ($urandom_range(0, 2) == 0);
      rxd = 8'($urandom);
      hwr = 1'b0; hrd = 1'b0;
      if (r < 30) begin hwr = 1'b1; ha = 3'd0; hwd = 8'($urandom); end
      else if (r < 55) begin hrd = 1'b1; ha = 3'(($urandom_range(0, 5))); end
      else if (r < 62) begin hwr = 1'b1; ha = 3'd2; hwd = 8'($urandom); end
      else if (r < 65) begin hwr = 1'b1; ha = 3'd3; hwd = 8'($urandom); end
      else if (r < 67) begin hwr = 1'b1; ha = 3'd1; hwd = 8'($urandom); end
      else if (r == 67) begin hwr = 1'b1; ha = 3'd4; hwd = 8'($urandom); end
      aa = $urandom_range(0, 1) == 1; ab = $urandom_range(0, 1) == 1;
      step();
    end
    hwr = 1'b0; hrd = 1'b0; txr = 1'b0; rxv = 1'b0;
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule